// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a legacy multi-function I/O controller. It sits on a byte-wide I/O bus and answers at two adjacent addresses: an even address that acts as the register selector (index port) and the next odd address that carries register contents (data port). A strap input picks which of two fixed base addresses the pair occupies. After reset the port is locked. Data accesses have no effect and read as all ones until the host writes a specific key byte twice in a row to the index port. A different key byte written to the index port locks it again.

Once the port is unlocked, the host writes a register number to the index port and then reads or writes that register through the data port. The index stays put, so a read-modify-write needs only one index write. The low register space is global. It holds the chip identity, the logical-device selector and a small set of option bytes. The space from 0x30 upward is banked: the selector picks which logical device's enable byte and window of settings registers the data port reaches. Every global option byte and every device's banked bytes are driven out continuously, so the attached peripheral blocks see their configuration without a bus.

Requests take one cycle and are never stalled. A read that hits one of the two ports returns its byte on `rsp_data` with `rsp_valid` one cycle later. There is no ready signal, so the host cannot apply back-pressure and must take the response in that cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: The index port is at base and the data port at base+1, where base is 0x2E when `base_sel`=0 and 0x4E when `base_sel`=1. Requests to any other address produce no response and change no state.
- R2: The port unlocks only after two consecutive index-port writes of 0x87 made while locked.
- R3: While locked, an index-port write of any value other than 0x87 restarts the key count, so the sequence 0x87, other, 0x87 leaves the port locked.
- R4: While locked, reads of either port return 0xFF and data-port writes change no register.
- R5: While unlocked, an index-port write of 0xAA locks the port again and does not change the index register.
- R6: While unlocked, any other index-port write loads the 8-bit index register, and an index-port read returns it. The index register keeps its value across data accesses and across relocking.
- R7: Register 0x20 reads the upper byte and 0x21 the lower byte of the 16-bit identity {CHIP_FAMILY[11:0], CHIP_REV[3:0]}. Writes to both are ignored.
- R8: Register 0x07 holds the logical-device number, which reads back as written. For device d < NUM_LDEV, register 0x30 is its enable byte, shown on `dev_en_o[8d+:8]`. Register 0xE0+k (k < BANK_REGS) is shown on `dev_reg_o[(d*BANK_REGS+k)*8+:8]`. Each device keeps its own copy.
- R9: Global option registers 0x22, 0x23, 0x24, 0x29, 0x2A and 0x2C are read/write. They are shown on `glb_cfg_o` in slots 0 to 5 in that order, with slot s at bits [8s+:8].
- R10: Unimplemented registers read 0x00 and ignore writes. This includes the whole banked space when the device number is NUM_LDEV or above, and the banked addresses outside 0x30 and the settings window.
- R11: Reset locks the port, clears the index and the device number to 0, and clears every global option, enable and settings byte.
- R12: A read that hits either port gives exactly one `rsp_valid` pulse in the next cycle. `rsp_valid` is never raised otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 1 | Base address strap: 0 selects 0x2E, 1 selects 0x4E |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | I/O address of the request |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present, one cycle after the read |
| rsp_data | output | 8 | Read response byte |
| glb_cfg_o | output | 48 | Global option bytes, slot s at [8s+:8] |
| dev_en_o | output | NUM_LDEV*8 | Enable byte of each logical device |
| dev_reg_o | output | NUM_LDEV*BANK_REGS*8 | Settings window of each logical device |

## Verification
The bench builds the block with NUM_LDEV=4, BANK_REGS=4 and CHIP_REV=5. The small device count lets it select device 5, which lies past the last implemented bank, and check that this bank reads zero and ignores writes. The short window puts 0xE4 just past the last settings register, so the window's upper edge is exercised. A non-zero revision makes the low identity byte distinguishable from a cleared register, and the bench drives both strap values to check that the ports move with the base.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] KEY_OPEN   = 8'h87;
  localparam logic [7:0] KEY_CLOSE  = 8'hAA;
  localparam logic [7:0] RA_LDN     = 8'h07;
  localparam logic [7:0] RA_ID_HI   = 8'h20;
  localparam logic [7:0] RA_ID_LO   = 8'h21;
  localparam logic [7:0] RA_BANKED  = 8'h30;
  localparam logic [7:0] RA_DEV_EN  = 8'h30;
  localparam logic [7:0] RA_WINDOW  = 8'hE0;
  localparam logic [7:0] BASE_LOW   = 8'h2E;
  localparam logic [7:0] BASE_HIGH  = 8'h4E;

  localparam int GLB_SLOTS = 6;

  typedef enum logic [1:0] {
    KS_SHUT  = 2'd0,
    KS_HALF  = 2'd1,
    KS_OPEN  = 2'd2
  } key_state_t;

  // Map a global register number to its option slot; GLB_SLOTS means none.
  function automatic int unsigned glb_slot(input logic [7:0] ra);
    case (ra)
      8'h22:   return 0;
      8'h23:   return 1;
      8'h24:   return 2;
      8'h29:   return 3;
      8'h2A:   return 4;
      8'h2C:   return 5;
      default: return GLB_SLOTS;
    endcase
  endfunction

endpackage

// File: rtl/sio_key_unlock.sv
module sio_key_unlock
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o
);

  key_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      case (st_q)
        KS_SHUT: st_d = (wdata == KEY_OPEN) ? KS_HALF : KS_SHUT;
        KS_HALF: st_d = (wdata == KEY_OPEN) ? KS_OPEN : KS_SHUT;
        KS_OPEN: st_d = (wdata == KEY_CLOSE) ? KS_SHUT : KS_OPEN;
        default: st_d = KS_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_SHUT;
    else        st_q <= st_d;
  end

  assign open_o = (st_q == KS_OPEN);

endmodule

// File: rtl/sio_glb_regs.sv
module sio_glb_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [11:0] CHIP_FAMILY = 12'hA23,
  parameter logic [3:0]  CHIP_REV    = 4'h0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             ra,
  input  logic [7:0]             wdata,
  output logic [7:0]             ldn_o,
  output logic [GLB_SLOTS*8-1:0] glb_o,
  output logic [7:0]             rd_o
);

  localparam logic [15:0] IDENT = {CHIP_FAMILY, CHIP_REV};

  logic [7:0]  opt_q [GLB_SLOTS];
  logic [7:0]  ldn_q;
  int unsigned slot;

  assign slot = glb_slot(ra);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldn_q <= 8'h00;
      for (int s = 0; s < GLB_SLOTS; s++) opt_q[s] <= 8'h00;
    end else if (wr_en) begin
      if (ra == RA_LDN) ldn_q <= wdata;
      for (int s = 0; s < GLB_SLOTS; s++)
        if (slot == s) opt_q[s] <= wdata;
    end
  end

  always_comb begin
    rd_o = 8'h00;
    case (ra)
      RA_LDN:   rd_o = ldn_q;
      RA_ID_HI: rd_o = IDENT[15:8];
      RA_ID_LO: rd_o = IDENT[7:0];
      default: begin
        for (int s = 0; s < GLB_SLOTS; s++)
          if (slot == s) rd_o = opt_q[s];
      end
    endcase
  end

  for (genvar s = 0; s < GLB_SLOTS; s++) begin : g_exp
    assign glb_o[s*8 +: 8] = opt_q[s];
  end

  assign ldn_o = ldn_q;

endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
  import sio_cfg_pkg::*;
#(
  parameter int BANK_REGS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             ra,
  input  logic [7:0]             wdata,
  output logic [7:0]             en_o,
  output logic [BANK_REGS*8-1:0] regs_o,
  output logic [7:0]             rd_o
);

  logic [7:0]  en_q;
  logic [7:0]  win_q [BANK_REGS];
  logic [31:0] off;
  logic        in_win;

  assign off    = {24'd0, ra} - {24'd0, RA_WINDOW};
  assign in_win = (ra >= RA_WINDOW) && (off < 32'(BANK_REGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 8'h00;
      for (int k = 0; k < BANK_REGS; k++) win_q[k] <= 8'h00;
    end else if (wr_en) begin
      if (ra == RA_DEV_EN) en_q <= wdata;
      for (int k = 0; k < BANK_REGS; k++)
        if (in_win && off == 32'(k)) win_q[k] <= wdata;
    end
  end

  always_comb begin
    rd_o = 8'h00;
    if (ra == RA_DEV_EN) rd_o = en_q;
    for (int k = 0; k < BANK_REGS; k++)
      if (in_win && off == 32'(k)) rd_o = win_q[k];
  end

  for (genvar k = 0; k < BANK_REGS; k++) begin : g_exp
    assign regs_o[k*8 +: 8] = win_q[k];
  end

  assign en_o = en_q;

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          NUM_LDEV    = 12,
  parameter int          BANK_REGS   = 8,
  parameter logic [11:0] CHIP_FAMILY = 12'hA23,
  parameter logic [3:0]  CHIP_REV    = 4'h0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            base_sel,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [7:0]                      req_wdata,
  output logic                            rsp_valid,
  output logic [7:0]                      rsp_data,
  output logic [GLB_SLOTS*8-1:0]          glb_cfg_o,
  output logic [NUM_LDEV*8-1:0]           dev_en_o,
  output logic [NUM_LDEV*BANK_REGS*8-1:0] dev_reg_o
);

  localparam logic [ADDR_W-1:0] BASE0 = ADDR_W'(BASE_LOW);
  localparam logic [ADDR_W-1:0] BASE1 = ADDR_W'(BASE_HIGH);
  localparam int                DEV_BYTES = BANK_REGS * 8;

  logic [ADDR_W-1:0] base;
  logic              hit, at_data, idx_wr, dat_wr, dat_rd;
  logic              unlocked;
  logic [7:0]        idx_q;
  logic [7:0]        ldn;
  logic [7:0]        glb_rd, bank_rd, rd_mux;
  logic              glb_wr, upper;
  logic [NUM_LDEV-1:0] bank_wr;
  logic [7:0]        bank_rd_arr [NUM_LDEV];

  // Port decode: the pair sits on an even base.
  assign base    = base_sel ? BASE1 : BASE0;
  assign hit     = req_valid && (req_addr[ADDR_W-1:1] == base[ADDR_W-1:1]);
  assign at_data = req_addr[0];
  assign idx_wr  = hit && req_write && !at_data;
  assign dat_wr  = hit && req_write && at_data && unlocked;
  assign dat_rd  = hit && !req_write;

  sio_key_unlock u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .wdata  (req_wdata),
    .open_o (unlocked)
  );

  // Index register: loaded only while open, key bytes excluded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= 8'h00;
    else if (idx_wr && unlocked && req_wdata != KEY_CLOSE)
      idx_q <= req_wdata;
  end

  assign upper  = (idx_q >= RA_BANKED);
  assign glb_wr = dat_wr && !upper;

  sio_glb_regs #(
    .CHIP_FAMILY (CHIP_FAMILY),
    .CHIP_REV    (CHIP_REV)
  ) u_glb (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (glb_wr),
    .ra    (idx_q),
    .wdata (req_wdata),
    .ldn_o (ldn),
    .glb_o (glb_cfg_o),
    .rd_o  (glb_rd)
  );

  for (genvar d = 0; d < NUM_LDEV; d++) begin : g_dev
    assign bank_wr[d] = dat_wr && upper && (ldn == 8'(d));
    sio_ldev_bank #(
      .BANK_REGS (BANK_REGS)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_wr[d]),
      .ra     (idx_q),
      .wdata  (req_wdata),
      .en_o   (dev_en_o[d*8 +: 8]),
      .regs_o (dev_reg_o[d*DEV_BYTES +: DEV_BYTES]),
      .rd_o   (bank_rd_arr[d])
    );
  end

  // Devices at or past NUM_LDEV leave bank_rd at zero.
  always_comb begin
    bank_rd = 8'h00;
    for (int d = 0; d < NUM_LDEV; d++)
      if (ldn == 8'(d)) bank_rd = bank_rd_arr[d];
  end

  always_comb begin
    if (!unlocked)     rd_mux = 8'hFF;
    else if (!at_data) rd_mux = idx_q;
    else if (upper)    rd_mux = bank_rd;
    else               rd_mux = glb_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= dat_rd;
      if (dat_rd) rsp_data <= rd_mux;
    end
  end

endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk #(
  parameter int ADDR_W   = 16,
  parameter int NUM_LDEV = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   base_sel,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [ADDR_W-1:0]      req_addr,
  input logic [7:0]             req_wdata,
  input logic                   rsp_valid,
  input logic [7:0]             rsp_data,
  input logic                   unlocked,
  input logic [47:0]            glb_cfg_o,
  input logic [NUM_LDEV*8-1:0]  dev_en_o
);

  logic [ADDR_W-1:0] b;
  logic              at_idx, at_dat, armed;

  assign b      = base_sel ? ADDR_W'(8'h4E) : ADDR_W'(8'h2E);
  assign at_idx = req_valid && (req_addr == b);
  assign at_dat = req_valid && (req_addr == b + ADDR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_rsp_follows_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((at_idx || at_dat) && !req_write) |=> rsp_valid);

  p_rsp_has_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_valid) |-> $past((at_idx || at_dat) && !req_write));

  p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_valid && $past(!unlocked)) |-> rsp_data == 8'hFF);

  p_locked_write_inert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && at_dat && req_write) |=> ($stable(glb_cfg_o) && $stable(dev_en_o)));

  p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(unlocked)) |-> $past(at_idx && req_write && req_wdata == 8'h87));

  p_close_needs_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(unlocked)) |-> $past(at_idx && req_write && req_wdata == 8'hAA));

endmodule

bind sio_cfg_port sio_cfg_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_LDEV (NUM_LDEV)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .base_sel  (base_sel),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .unlocked  (unlocked),
  .glb_cfg_o (glb_cfg_o),
  .dev_en_o  (dev_en_o)
);

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;

  localparam int ADDR_W = 16;
  localparam int NL     = 4;
  localparam int BR     = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                base_sel = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_write = 1'b0;
  logic [ADDR_W-1:0]   req_addr = '0;
  logic [7:0]          req_wdata = 8'h00;
  logic                rsp_valid;
  logic [7:0]          rsp_data;
  logic [47:0]         glb_cfg_o;
  logic [NL*8-1:0]     dev_en_o;
  logic [NL*BR*8-1:0]  dev_reg_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_extra = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb [$];

  always #2 clk = ~clk;

  sio_cfg_port #(
    .ADDR_W    (ADDR_W),
    .NUM_LDEV  (NL),
    .BANK_REGS (BR),
    .CHIP_REV  (4'h5)
  ) i_sio_cfg_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_sel  (base_sel),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .glb_cfg_o (glb_cfg_o),
    .dev_en_o  (dev_en_o),
    .dev_reg_o (dev_reg_o)
  );

  function automatic logic [ADDR_W-1:0] ip();
    return base_sel ? ADDR_W'(16'h4E) : ADDR_W'(16'h2E);
  endfunction

  // Monitor: pop the scoreboard on every response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        n_extra++;
      end else begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (rsp_data !== e.exp) begin
          n_bad++;
          $display("FAIL %s: got %02h expected %02h", e.tag, rsp_data, e.exp);
        end
      end
    end
  end

  task automatic bus(input logic [ADDR_W-1:0] a, input logic wr, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wi(input logic [7:0] d); bus(ip(), 1'b1, d); endtask
  task automatic wd(input logic [7:0] d); bus(ip() + 1, 1'b1, d); endtask
  task automatic rd_dat(input logic [7:0] e, input string tag);
    exp_t x; x.exp = e; x.tag = tag; sb.push_back(x);
    bus(ip() + 1, 1'b0, 8'h00);
  endtask
  task automatic rd_idx(input logic [7:0] e, input string tag);
    exp_t x; x.exp = e; x.tag = tag; sb.push_back(x);
    bus(ip(), 1'b0, 8'h00);
  endtask
  task automatic wreg(input logic [7:0] r, input logic [7:0] d); wi(r); wd(d); endtask
  task automatic rreg(input logic [7:0] r, input logic [7:0] e, input string tag);
    wi(r); rd_dat(e, tag);
  endtask
  task automatic unlock(); wi(8'h87); wi(8'h87); endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    @(negedge clk);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 glb", 64'(glb_cfg_o), 64'd0);
    chk("R11 dev_en", 64'(dev_en_o), 64'd0);
    chk("R11 dev_reg", dev_reg_o[63:0], 64'd0);

    // R4: locked reads
    rd_dat(8'hFF, "R4 locked data read");
    rd_idx(8'hFF, "R4 locked index read");

    // R2 + R9: open, write option, close (R5), locked write ignored (R4)
    unlock();
    rd_idx(8'h00, "R11 index after reset");
    wreg(8'h24, 8'h02);
    chk("R9 slot2", 64'(glb_cfg_o[23:16]), 64'h02);
    wi(8'hAA);
    rd_dat(8'hFF, "R5 relocked read");
    wd(8'h00);
    chk("R4 locked write ignored", 64'(glb_cfg_o[23:16]), 64'h02);

    // R3: broken key sequence
    wi(8'h87); wi(8'h12); wi(8'h87);
    rd_dat(8'hFF, "R3 broken key stays locked");
    wi(8'h87);
    rd_idx(8'h24, "R6 index kept across relock");
    rd_dat(8'h02, "R6 data via kept index");

    // R2: single key after relock is not enough
    wi(8'hAA); wi(8'h87);
    rd_dat(8'hFF, "R2 one key stays locked");
    wi(8'h87);

    // R7: identity
    rreg(8'h20, 8'hA2, "R7 id high");
    rreg(8'h21, 8'h35, "R7 id low");
    wreg(8'h20, 8'h00);
    rd_dat(8'hA2, "R7 id write ignored");

    // R8: banked device registers
    wreg(8'h07, 8'h01);
    wreg(8'h30, 8'h05);
    wreg(8'hE2, 8'h3C);
    wreg(8'h07, 8'h02);
    rreg(8'h30, 8'h00, "R8 device 2 enable separate");
    wd(8'h81);
    wreg(8'h07, 8'h01);
    rreg(8'h30, 8'h05, "R8 device 1 enable kept");
    rreg(8'hE2, 8'h3C, "R8 device 1 window");
    rreg(8'h07, 8'h01, "R8 ldn readback");
    chk("R8 dev_en", 64'(dev_en_o), 64'h0081_0500);
    chk("R8 dev_reg", 64'(dev_reg_o[(1*BR+2)*8 +: 8]), 64'h3C);

    // R10: out-of-range device, window edge, unimplemented global
    rreg(8'hE4, 8'h00, "R10 past window");
    wreg(8'h07, 8'h05);
    wreg(8'h30, 8'hFF);
    rd_dat(8'h00, "R10 missing device reads 0");
    chk("R10 missing device write ignored", 64'(dev_en_o), 64'h0081_0500);
    wreg(8'h25, 8'h77);
    rd_dat(8'h00, "R10 unimplemented global");

    // R6: read-modify-write with one index write
    wi(8'h2C);
    rd_dat(8'h00, "R6 rmw first read");
    wd(8'h02);
    rd_dat(8'h02, "R6 rmw reread");

    // R9: global option mapping
    wreg(8'h22, 8'h11); wreg(8'h23, 8'h22); wreg(8'h29, 8'h44); wreg(8'h2A, 8'h55);
    chk("R9 glb map", 64'(glb_cfg_o), 64'h02_55_44_02_22_11);

    // R1: base strap
    wi(8'hAA);
    base_sel = 1'b1;
    bus(16'h002E, 1'b1, 8'h87); bus(16'h002E, 1'b1, 8'h87);
    rd_dat(8'hFF, "R1 old base does not unlock");
    bus(16'h002F, 1'b0, 8'h00);
    unlock();
    rreg(8'h20, 8'hA2, "R1 high base id");
    bus(16'h004C, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    chk("R1 no response off base", 64'(n_extra), 64'd0);
    chk("R12 scoreboard drained", 64'(sb.size()), 64'd0);

    finish_run();
  end

endmodule